// File: doc/BRIEF.md
# Decimating Ring-Buffer Address Generator

This block produces data-memory addresses for a small filter processor that runs several decimating subfilters out of one shared memory. A base register (segment), an in-filter tap index (tap offset) and a sample ring pointer are combined into one address. The address is formed as base plus ((tap offset minus the ring pointer divided by the stage divisor, rounded down) modulo the stage length). Because of this, one ring pointer that advances once per incoming sample serves every stage, even though each stage runs at its own decimated rate.

A stage-select input picks the divisor and modulus pair for the stage the processor is running. The division is a power-of-two shift. The modulus is never computed by a divider. Each stage keeps its own reduced pointer, which advances whenever the shared ring pointer crosses a multiple of that stage's divisor. The final reduction is one conditional add or subtract.

A four-word, 20-bit sample FIFO sits in front of the processor. It has full and empty flags. A sticky error flag records any push that was refused because the FIFO was full, and any pop that was refused because it was empty.

Top module: `decim_ring_agen`

## Requirements
- R1: After reset, addr is 0, empty is 1, full is 0 and err is 0. Internally, the segment, the tap offset and the ring pointer are all 0.
- R2: addr equals (segment + r) mod 256, where r is the non-negative residue of (tap offset − floor(ring/k1)) modulo k2. addr follows the current register values and the current stage_sel within the same cycle.
- R3: The stage_sel codes select these constants: 0 → k1=1, k2=1; 1 → k1=2, k2=1; 2 → k1=4, k2=22; 3 → k1=4, k2=15.
- R4: The ring pointer rises by one on each clock with of2_inc=1 and holds otherwise. After 1319 it wraps to 0.
- R5: seg_ld loads seg_val into the segment. of1_ld loads of1_val into the tap offset and takes priority over of1_inc. of1_inc advances the tap offset by one and wraps to 0 after k2−1 of the selected stage, so with k2=1 it stays 0.
- R6: The FIFO returns 20-bit words in the order they were pushed. While empty is 0, pop_data shows the oldest word. A pop that is accepted removes that word.
- R7: full is 1 exactly when four words are held, and empty is 1 exactly when none are held.
- R8: A push while full leaves the contents unchanged. A pop while empty removes nothing. Either one sets err, and err stays 1 until reset.
- R9: A push and a pop in the same cycle are judged against the flags as they stood before that clock edge.
  - With neither flag set, both are taken and the count is unchanged.
  - When full, the pop is taken, the push is dropped and err is set.
  - When empty, the push is taken, the pop is dropped and err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_sel | input | 2 | Stage code selecting k1 and k2 |
| seg_ld | input | 1 | Load seg_val into the segment register |
| seg_val | input | 8 | Segment base address |
| of1_ld | input | 1 | Load of1_val into the tap offset |
| of1_val | input | 5 | Tap offset load value |
| of1_inc | input | 1 | Advance the tap offset modulo k2 |
| of2_inc | input | 1 | Advance the shared ring pointer (one per sample) |
| addr | output | 8 | Physical data-memory address |
| push | input | 1 | Write push_data into the FIFO |
| push_data | input | 20 | Incoming sample |
| pop | input | 1 | Remove the oldest FIFO word |
| pop_data | output | 20 | Oldest FIFO word |
| full | output | 1 | FIFO holds four words |
| empty | output | 1 | FIFO holds no word |
| err | output | 1 | Sticky refused-push or refused-pop flag |

## Verification
The range check on the address offset assumes that the tap offset is below k2 of the selected stage, so it is only applied while that holds. The per-stage pointer checks assume that the ring wrap value is a multiple of k1·k2 for every stage. The stimulus keeps within this: it loads only in-range tap offsets, and it reloads the tap offset in the same cycle that it changes stage_sel. The FIFO checks take the flags as they stood before each edge. The bench drives pushes and pops, including simultaneous ones, against full, empty and partly filled states.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int NUM_STAGES = 4;
  localparam int STG_W      = $clog2(NUM_STAGES);
  localparam int OFS_W      = 5;

  typedef enum logic [STG_W-1:0] {ST_HB1, ST_HB2, ST_HB3, ST_EQ} stage_e;

  // log2 of the ring divisor k1 for each stage
  function automatic int stage_shift(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      default: return 2;
    endcase
  endfunction

  // ring length k2 for each stage
  function automatic int stage_mod(input int s);
    case (s)
      0, 1:    return 1;
      2:       return 22;
      default: return 15;
    endcase
  endfunction

  // (a - b) mod m, with a and b each below m
  function automatic logic [OFS_W-1:0] ring_offset(input logic [OFS_W-1:0] a,
                                                   input logic [OFS_W-1:0] b,
                                                   input logic [OFS_W-1:0] m);
    logic signed [OFS_W+1:0] d;
    logic signed [OFS_W+1:0] sm;
    sm = $signed({2'b00, m});
    d  = $signed({2'b00, a}) - $signed({2'b00, b});
    if (d < 0)        d = d + sm;
    else if (d >= sm) d = d - sm;
    return d[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/agen_stage_ptr.sv
module agen_stage_ptr #(
  parameter int SHIFT = 0,
  parameter int MOD   = 1,
  parameter int OF2_W = 11,
  parameter int PW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wrap,
  input  logic [OF2_W-1:0] of2_nxt,
  output logic [PW-1:0]    ptr
);
  localparam logic [OF2_W-1:0] LOWMASK = OF2_W'((1 << SHIFT) - 1);
  localparam logic [PW-1:0]    LAST    = PW'(MOD - 1);

  logic tick;
  assign tick = step && ((of2_nxt & LOWMASK) == '0);

  always_ff @(posedge clk) begin
    if (rst)               ptr <= '0;
    else if (step && wrap) ptr <= '0;
    else if (tick)         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr));
endmodule

// File: rtl/agen_sample_fifo.sv
module agen_sample_fifo #(
  parameter int DATA_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LASTA = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     count_q;

  logic push_ok, pop_ok, push_drop, pop_drop;

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign push_drop = push && full;
  assign pop_drop  = pop && empty;
  assign pop_data  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      err     <= 1'b0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LASTA) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LASTA) ? '0 : rd_q + 1'b1;
      if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
      else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      if (push_drop || pop_drop) err <= 1'b1;
    end
  end

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R8
  push_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push_drop && !pop_ok) |=> ($stable(count_q) && $stable(wr_q)));

  // R8
  pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_drop && !push_ok) |=> ($stable(count_q) && $stable(rd_q)));

  // R9
  both_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(count_q));
endmodule

// File: rtl/decim_ring_agen.sv
module decim_ring_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 20,
  parameter int FIFO_DEPTH = 4,
  parameter int OF2_WRAP   = 1320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STG_W-1:0]  stage_sel,
  input  logic              seg_ld,
  input  logic [ADDR_W-1:0] seg_val,
  input  logic              of1_ld,
  input  logic [OFS_W-1:0]  of1_val,
  input  logic              of1_inc,
  input  logic              of2_inc,
  output logic [ADDR_W-1:0] addr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam int OF2_W = $clog2(OF2_WRAP);
  localparam logic [OF2_W-1:0] OF2_LAST = OF2_W'(OF2_WRAP - 1);

  logic [ADDR_W-1:0] seg_q;
  logic [OFS_W-1:0]  of1_q;
  logic [OF2_W-1:0]  of2_q, of2_nxt;
  logic              of2_wrap;
  logic [OFS_W-1:0]  ptr_arr [NUM_STAGES];
  logic [OFS_W-1:0]  cur_ptr, cur_k2, offset, of1_up;

  assign of2_wrap = (of2_q == OF2_LAST);
  assign of2_nxt  = of2_wrap ? '0 : of2_q + 1'b1;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    agen_stage_ptr #(
      .SHIFT(stage_shift(s)),
      .MOD  (stage_mod(s)),
      .OF2_W(OF2_W),
      .PW   (OFS_W)
    ) i_ptr (
      .clk    (clk),
      .rst    (rst),
      .step   (of2_inc),
      .wrap   (of2_wrap),
      .of2_nxt(of2_nxt),
      .ptr    (ptr_arr[s])
    );
  end

  always_comb begin
    cur_ptr = ptr_arr[stage_sel];
    cur_k2  = OFS_W'(stage_mod(int'(stage_sel)));
    offset  = ring_offset(of1_q, cur_ptr, cur_k2);
    of1_up  = ((of1_q + 1'b1) >= cur_k2) ? '0 : of1_q + 1'b1;
  end

  assign addr = seg_q + ADDR_W'(offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      of1_q <= '0;
      of2_q <= '0;
    end else begin
      if (seg_ld)       seg_q <= seg_val;
      if (of1_ld)       of1_q <= of1_val;
      else if (of1_inc) of1_q <= of1_up;
      if (of2_inc)      of2_q <= of2_nxt;
    end
  end

  agen_sample_fifo #(
    .DATA_W(DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) i_fifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_data(push_data),
    .pop      (pop),
    .pop_data (pop_data),
    .full     (full),
    .empty    (empty),
    .err      (err)
  );

  // R2
  addr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (of1_q < cur_k2) |-> (ADDR_W'(addr - seg_q) < ADDR_W'(cur_k2)));

  // R4
  of2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !of2_inc |=> $stable(of2_q));

  // R4
  of2_range_chk: assert property (@(posedge clk) disable iff (rst)
    of2_q < OF2_W'(OF2_WRAP));

  // R5
  of1_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (of1_inc && !of1_ld && (of1_q == cur_k2 - 1'b1)) |=> (of1_q == '0));
endmodule

// File: tb/test_decim_ring_agen.sv
module test_decim_ring_agen;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  stage_sel;
  logic        seg_ld, of1_ld, of1_inc, of2_inc, push, pop;
  logic [7:0]  seg_val;
  logic [4:0]  of1_val;
  logic [7:0]  addr;
  logic [19:0] push_data, pop_data;
  logic        full, empty, err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_seg, m_of1, m_of2, m_st;
  int q[$];
  bit m_err;

  always #2 clk = ~clk;

  decim_ring_agen i_decim_ring_agen (
    .clk(clk), .rst(rst), .stage_sel(stage_sel), .seg_ld(seg_ld),
    .seg_val(seg_val), .of1_ld(of1_ld), .of1_val(of1_val),
    .of1_inc(of1_inc), .of2_inc(of2_inc), .addr(addr), .push(push),
    .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .full(full), .empty(empty), .err(err)
  );

  function automatic int k1_of(int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic int k2_of(int s);
    return (s < 2) ? 1 : (s == 2) ? 22 : 15;
  endfunction

  function automatic int exp_addr();
    int r;
    r = (m_of1 - m_of2 / k1_of(m_st)) % k2_of(m_st);
    if (r < 0) r += k2_of(m_st);
    return (m_seg + r) % 256;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    seg_ld = 0; of1_ld = 0; of1_inc = 0; of2_inc = 0;
    push = 0; pop = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs(); stage_sel = 0; seg_val = 0; of1_val = 0; push_data = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    m_seg = 0; m_of1 = 0; m_of2 = 0; m_st = 0; q.delete(); m_err = 0;
  endtask

  // one address-side cycle
  task automatic acyc(string req, int st, bit lds, int sv, bit ld1, int v1,
                      bit inc1, bit inc2);
    @(negedge clk);
    stage_sel = 2'(st); seg_ld = lds; seg_val = 8'(sv);
    of1_ld = ld1; of1_val = 5'(v1); of1_inc = inc1; of2_inc = inc2;
    @(posedge clk); #1;
    m_st = st;
    if (lds) m_seg = sv;
    if (ld1) m_of1 = v1;
    else if (inc1) m_of1 = (m_of1 + 1 >= k2_of(st)) ? 0 : m_of1 + 1;
    if (inc2) m_of2 = (m_of2 + 1) % 1320;
    idle_inputs();
    chk(req, addr, exp_addr());
  endtask

  // one FIFO cycle
  task automatic fcyc(string req, bit ps, int d, bit pp);
    bit was_full, was_empty;
    @(negedge clk);
    push = ps; push_data = 20'(d); pop = pp;
    @(posedge clk); #1;
    was_full = (q.size() == 4);
    was_empty = (q.size() == 0);
    if (pp && !was_empty) void'(q.pop_front());
    if (ps && !was_full) q.push_back(d & 20'hFFFFF);
    if ((ps && was_full) || (pp && was_empty)) m_err = 1;
    idle_inputs();
    chk(req, full, q.size() == 4);
    chk(req, empty, q.size() == 0);
    chk(req, err, m_err);
    if (q.size() > 0) chk(req, pop_data, q[0]);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 addr", addr, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_stage_walk(int st, int sv, int v1, int steps);
    acyc("R3 load", st, 1, sv, 1, v1, 0, 0);
    for (int i = 0; i < steps; i++) acyc("R2 R4 step", st, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_of2_wrap();
    acyc("R4 setup", 2, 1, 40, 1, 5, 0, 0);
    while (m_of2 != 1310) acyc("R4 run", 2, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 16; i++) acyc("R4 wrap", 2, 0, 0, 0, 0, 0, 1);
    acyc("R4 wrap eq", 3, 0, 0, 1, 3, 0, 0);
    while (m_of2 != 1316) acyc("R4 run", 3, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 8; i++) acyc("R4 wrap eq", 3, 0, 0, 0, 0, 0, 1);
    acyc("R4 hold", 3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_of1();
    acyc("R5 load", 3, 1, 100, 1, 13, 0, 0);
    for (int i = 0; i < 3; i++) acyc("R5 inc", 3, 0, 0, 0, 0, 1, 0);
    acyc("R5 ld priority", 3, 0, 0, 1, 7, 1, 0);
    acyc("R5 inc+step", 3, 0, 0, 0, 0, 1, 1);
    acyc("R5 long", 2, 0, 0, 1, 20, 0, 0);
    for (int i = 0; i < 3; i++) acyc("R5 inc k22", 2, 0, 0, 0, 0, 1, 0);
    acyc("R5 k2=1", 0, 0, 0, 1, 0, 1, 0);
    acyc("R5 k2=1 inc", 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_fifo_order();
    do_reset();
    fcyc("R6 push", 1, 20'h12345, 0);
    fcyc("R6 push", 1, 20'hABCDE, 0);
    fcyc("R6 push", 1, 20'h00F0F, 0);
    for (int i = 0; i < 3; i++) fcyc("R6 pop", 0, 0, 1);
  endtask

  task automatic t_fifo_full();
    do_reset();
    for (int i = 0; i < 4; i++) fcyc("R7 fill", 1, 20'h1000 + i, 0);
    fcyc("R8 overflow", 1, 20'hFFFFF, 0);
    for (int i = 0; i < 4; i++) fcyc("R8 drain", 0, 0, 1);
    fcyc("R8 sticky", 0, 0, 0);
  endtask

  task automatic t_fifo_under();
    do_reset();
    fcyc("R8 underflow", 0, 0, 1);
    fcyc("R8 after underflow", 1, 20'h55AA5, 0);
    fcyc("R8 pop", 0, 0, 1);
  endtask

  task automatic t_fifo_simul();
    do_reset();
    fcyc("R9 both empty", 1, 20'h00001, 1);
    fcyc("R9 push", 1, 20'h00002, 0);
    fcyc("R9 both mid", 1, 20'h00003, 1);
    fcyc("R9 push", 1, 20'h00004, 0);
    fcyc("R9 push", 1, 20'h00005, 0);
    fcyc("R9 both full", 1, 20'h00006, 1);
    for (int i = 0; i < 3; i++) fcyc("R9 drain", 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_stage_walk(0, 10, 0, 6);
    t_stage_walk(1, 20, 0, 6);
    t_stage_walk(2, 250, 17, 60);
    t_stage_walk(3, 200, 9, 50);
    t_stage_walk(2, 0, 0, 30);
    t_of2_wrap();
    t_of1();
    t_fifo_order();
    t_fifo_full();
    t_fifo_under();
    t_fifo_simul();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule